// File: doc/BRIEF.md
# Mixed-Decay Stepper Chopper Controller

This block controls one winding of a two-phase bipolar stepper through a four-switch H-bridge. A direction bit and two level-select bits are decoded into a signed current-level code. That code goes to an external DAC, which sets the comparator reference. The external current comparator sends back a raw flag once the winding current reaches the reference. The block schedules a fixed chopping period of sixteen oscillator ticks, and in each period it chooses between charge, slow decay and fast decay.

Every period opens in charge so that the comparator can be sampled. For a fixed number of system clocks after charge begins, the comparator is not looked at, which masks the switching spike. A trip seen before tick 6 of the period parks the bridge in slow decay, and tick 6 then switches it to fast decay for the rest of the period. A trip seen at or after tick 6 goes straight to fast decay. The oscillator is modelled as a one-cycle strobe in the system clock domain, and a low standby input stops the sequence and opens every switch.

Top module: `stepper_chop_ctrl`

## Requirements
- R1: `dac_code[1:0]` is the magnitude taken from {`lvl_a`,`lvl_b`}: 3 = 100%, 2 = 71%, 1 = 38%, 0 = zero current. `dac_code[2]` is 1 only when the magnitude is nonzero and `phase_dir` is 0. When the magnitude is zero, the direction is ignored.
- R2: Direction and level are captured only at the start of a period. Changes between period starts alter neither `dac_code` nor the switch outputs.
- R3: A period is sixteen `osc_tick` strobes. The period starts on the strobe that follows position 15, and after reset or standby on the first strobe. With a nonzero level, every period begins in charge. `mode_o` encodes 0 = off, 1 = charge, 2 = slow decay, 3 = fast decay.
- R4: The comparator input passes through a two-flop synchronizer. It is ignored for `BLANK_CYC` system clocks after each entry into charge.
- R5: A trip accepted before position 6 gives slow decay. The strobe that reaches position 6 turns slow decay into fast decay, which then holds to the end of the period.
- R6: A trip accepted at or after position 6 gives fast decay at once. With no trip, charge holds for the whole period.
- R7: For positive current, the outputs {`hi_pos`,`lo_pos`,`hi_neg`,`lo_neg`} are 1001 in charge, 0101 in slow decay and 0110 in fast decay.
- R8: For negative current, the same outputs are 0110 in charge, 0101 in slow decay and 1001 in fast decay.
- R9: A zero level keeps `mode_o` at off and all four switches open for the whole period, even while the comparator trips.
- R10: Reset, or `standby_n` low, opens all switches, clears `dac_code` and rewinds the position. While standby lasts, strobes have no effect. After standby is released, nothing switches until the next strobe starts a period.
- R11: When an accepted trip falls in the same cycle as the strobe that reaches position 6, the result is fast decay. When anything falls in the same cycle as the period-start strobe, the result is charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_n | input | 1 | Low stops the chopper and opens the bridge |
| osc_tick | input | 1 | One-cycle strobe per chopping-oscillator clock |
| phase_dir | input | 1 | 1 = current from out+ to out- |
| lvl_a | input | 1 | Level select, upper bit |
| lvl_b | input | 1 | Level select, lower bit |
| cmp_trip | input | 1 | Raw comparator flag, asynchronous |
| dac_code | output | 3 | Signed level to the reference DAC |
| mode_o | output | 2 | Present bridge mode |
| hi_pos | output | 1 | High-side switch, out+ leg |
| lo_pos | output | 1 | Low-side switch, out+ leg |
| hi_neg | output | 1 | High-side switch, out- leg |
| lo_neg | output | 1 | Low-side switch, out- leg |

## Verification
Two events can fall in the same cycle. An accepted comparator trip can coincide with the strobe that reaches the mixed-decay point, and a trip can coincide with the strobe that wraps the period. The bench raises the comparator exactly two clocks ahead of the chosen strobe, so the synchronized flag and the strobe reach the state register on one edge. It then judges the outcome: fast decay in the first case, a fresh charge with blanking restarted in the second. A design that tests the old position would settle in slow decay instead.

// File: rtl/stepchop_pkg.sv
package stepchop_pkg;

    typedef enum logic [1:0] {
        BR_OFF    = 2'd0,
        BR_CHARGE = 2'd1,
        BR_SLOW   = 2'd2,
        BR_FAST   = 2'd3
    } bridge_mode_e;

    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } coil_level_t;

    typedef struct packed {
        logic hi_p;
        logic lo_p;
        logic hi_n;
        logic lo_n;
    } sw_set_t;

    function automatic coil_level_t decode_level(logic dir, logic sel_a, logic sel_b);
        coil_level_t r;
        r.mag = {sel_a, sel_b};
        r.neg = (r.mag != 2'd0) && !dir;
        return r;
    endfunction

    // Positive current: charge drives out+ high and out- low.
    function automatic sw_set_t bridge_pattern(bridge_mode_e m, logic neg);
        sw_set_t s;
        s = '0;
        case (m)
            BR_CHARGE: s = neg ? 4'b0110 : 4'b1001;
            BR_SLOW:   s = 4'b0101;
            BR_FAST:   s = neg ? 4'b1001 : 4'b0110;
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int PERIOD = 16,
    parameter int MDT    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic osc_tick,
    output logic period_start,
    output logic mdt_hit,
    output logic past_mdt
);
    localparam int PW = $clog2(PERIOD);
    localparam logic [PW-1:0] POS_LAST = PW'(PERIOD - 1);
    localparam logic [PW-1:0] POS_PRE  = PW'(MDT - 1);
    localparam logic [PW-1:0] POS_MDT  = PW'(MDT);

    logic [PW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos <= POS_LAST;
        end else if (osc_tick) begin
            pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
        end
    end

    assign period_start = run && osc_tick && (pos == POS_LAST);
    assign mdt_hit      = run && osc_tick && (pos == POS_PRE);
    assign past_mdt     = (pos >= POS_MDT) && (pos != POS_LAST || !period_start);
endmodule

// File: rtl/trip_qual.sv
module trip_qual #(
    parameter int BLANK_CYC   = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_raw,
    input  logic restart,
    output logic trip_ok
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [BW-1:0]          blank;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_STAGES-2:0], cmp_raw};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= cmp_raw;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                 blank <= '0;
        else if (restart)        blank <= BW'(BLANK_CYC);
        else if (blank != '0)    blank <= blank - 1'b1;
    end

    assign trip_ok = chain[SYNC_STAGES-1] && (blank == '0);
endmodule

// File: rtl/decay_fsm.sv
module decay_fsm
    import stepchop_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         period_start,
    input  logic         mdt_hit,
    input  logic         past_mdt,
    input  logic         trip_ok,
    input  coil_level_t  lvl_in,
    output bridge_mode_e mode,
    output coil_level_t  level,
    output logic         charge_enter
);
    assign charge_enter = period_start && (lvl_in.mag != 2'd0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            mode  <= BR_OFF;
            level <= '0;
        end else if (period_start) begin
            level <= lvl_in;
            mode  <= (lvl_in.mag == 2'd0) ? BR_OFF : BR_CHARGE;
        end else begin
            case (mode)
                BR_CHARGE: if (trip_ok) mode <= (mdt_hit || past_mdt) ? BR_FAST : BR_SLOW;
                BR_SLOW:   if (mdt_hit) mode <= BR_FAST;
                default:   mode <= mode;
            endcase
        end
    end
endmodule

// File: rtl/stepper_chop_ctrl.sv
module stepper_chop_ctrl
    import stepchop_pkg::*;
#(
    parameter int PERIOD_TICKS = 16,
    parameter int MDT_TICK     = 6,
    parameter int BLANK_CYC    = 40,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby_n,
    input  logic       osc_tick,
    input  logic       phase_dir,
    input  logic       lvl_a,
    input  logic       lvl_b,
    input  logic       cmp_trip,
    output logic [2:0] dac_code,
    output logic [1:0] mode_o,
    output logic       hi_pos,
    output logic       lo_pos,
    output logic       hi_neg,
    output logic       lo_neg
);
    logic         period_start;
    logic         mdt_hit;
    logic         past_mdt;
    logic         trip_ok;
    logic         charge_enter;
    coil_level_t  lvl_in;
    coil_level_t  level;
    bridge_mode_e mode;
    sw_set_t      sw;

    assign lvl_in = decode_level(phase_dir, lvl_a, lvl_b);

    chop_timer #(.PERIOD(PERIOD_TICKS), .MDT(MDT_TICK)) timer_i (
        .clk(clk), .rst(rst), .run(standby_n), .osc_tick(osc_tick),
        .period_start(period_start), .mdt_hit(mdt_hit), .past_mdt(past_mdt)
    );

    trip_qual #(.BLANK_CYC(BLANK_CYC), .SYNC_STAGES(SYNC_STAGES)) qual_i (
        .clk(clk), .rst(rst), .cmp_raw(cmp_trip),
        .restart(charge_enter), .trip_ok(trip_ok)
    );

    decay_fsm fsm_i (
        .clk(clk), .rst(rst), .run(standby_n),
        .period_start(period_start), .mdt_hit(mdt_hit), .past_mdt(past_mdt),
        .trip_ok(trip_ok), .lvl_in(lvl_in),
        .mode(mode), .level(level), .charge_enter(charge_enter)
    );

    assign sw       = bridge_pattern(mode, level.neg);
    assign hi_pos   = sw.hi_p;
    assign lo_pos   = sw.lo_p;
    assign hi_neg   = sw.hi_n;
    assign lo_neg   = sw.lo_n;
    assign dac_code = level;
    assign mode_o   = mode;
endmodule

// File: rtl/stepper_chop_ctrl_chk.sv
module stepper_chop_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       standby_n,
    input logic       osc_tick,
    input logic [2:0] dac_code,
    input logic [1:0] mode_o,
    input logic       hi_pos,
    input logic       lo_pos,
    input logic       hi_neg,
    input logic       lo_neg
);
    logic [3:0] swv;
    assign swv = {hi_pos, lo_pos, hi_neg, lo_neg};

    assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!osc_tick && standby_n) |=> $stable(dac_code));

    assert_charge_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1 && $past(mode_o) != 2'd1) |-> $past(osc_tick));

    assert_slow_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2 && !osc_tick && standby_n) |=> (mode_o == 2'd2));

    assert_fast_no_slow_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd3) |=> (mode_o != 2'd2));

    assert_slow_pattern_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> (swv == 4'b0101));

    assert_zero_open_R9: assert property (@(posedge clk) disable iff (rst)
        (dac_code[1:0] == 2'd0) |-> (swv == 4'b0000));

    assert_standby_open_R10: assert property (@(posedge clk) disable iff (rst)
        !standby_n |=> (swv == 4'b0000 && dac_code == 3'd0));
endmodule

bind stepper_chop_ctrl stepper_chop_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .standby_n(standby_n), .osc_tick(osc_tick),
    .dac_code(dac_code), .mode_o(mode_o),
    .hi_pos(hi_pos), .lo_pos(lo_pos), .hi_neg(hi_neg), .lo_neg(lo_neg)
);

// File: tb/stepper_chop_ctrl_tb_top.sv
module stepper_chop_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby_n = 1'b1;
    logic       osc_tick = 1'b0;
    logic       phase_dir = 1'b0;
    logic       lvl_a = 1'b0;
    logic       lvl_b = 1'b0;
    logic       cmp_trip = 1'b0;
    logic [2:0] dac_code;
    logic [1:0] mode_o;
    logic       hi_pos, lo_pos, hi_neg, lo_neg;
    logic [3:0] sw;

    int errors = 0;
    int checks = 0;
    int pos_b  = 15;
    bit done   = 0;

    always #5 clk = ~clk;

    assign sw = {hi_pos, lo_pos, hi_neg, lo_neg};

    stepper_chop_ctrl dut_i (
        .clk(clk), .rst(rst), .standby_n(standby_n), .osc_tick(osc_tick),
        .phase_dir(phase_dir), .lvl_a(lvl_a), .lvl_b(lvl_b), .cmp_trip(cmp_trip),
        .dac_code(dac_code), .mode_o(mode_o),
        .hi_pos(hi_pos), .lo_pos(lo_pos), .hi_neg(hi_neg), .lo_neg(lo_neg)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
        pos_b = (pos_b + 1) % 16;
    endtask

    task automatic advance_to(input int target);
        while (pos_b != target) begin
            tick();
            idle(2);
        end
    endtask

    task automatic t_reset();
        chk("R10 reset mode", mode_o, 0);
        chk("R10 reset switches", sw, 0);
        chk("R10 reset dac", dac_code, 0);
    endtask

    task automatic t_early_trip_pos();
        phase_dir = 1; lvl_a = 1; lvl_b = 1; cmp_trip = 0;
        tick();
        chk("R1 dac full positive", dac_code, 3'b011);
        chk("R3 period opens in charge", mode_o, 1);
        chk("R7 charge pattern", sw, 4'b1001);
        cmp_trip = 1;
        idle(20);
        chk("R4 trip blanked", mode_o, 1);
        idle(30);
        chk("R5 early trip slow", mode_o, 2);
        chk("R7 slow pattern", sw, 4'b0101);
        advance_to(5);
        chk("R5 slow until mixed point", mode_o, 2);
        tick();
        chk("R5 fast at mixed point", mode_o, 3);
        chk("R7 fast pattern", sw, 4'b0110);
        cmp_trip = 0;
        advance_to(15);
        chk("R5 fast to period end", mode_o, 3);
    endtask

    task automatic t_late_trip();
        tick();
        chk("R3 charge again", mode_o, 1);
        idle(50);
        advance_to(6);
        chk("R6 no trip keeps charge", mode_o, 1);
        tick();
        cmp_trip = 1;
        idle(5);
        chk("R6 late trip fast", mode_o, 3);
        cmp_trip = 0;
        advance_to(15);
        chk("R6 fast held", mode_o, 3);
    endtask

    task automatic t_negative_and_hold();
        phase_dir = 0; lvl_a = 1; lvl_b = 0;
        tick();
        chk("R1 dac 71 negative", dac_code, 3'b110);
        chk("R8 charge pattern", sw, 4'b0110);
        cmp_trip = 1;
        idle(50);
        chk("R8 slow pattern", sw, 4'b0101);
        advance_to(6);
        chk("R8 fast pattern", sw, 4'b1001);
        cmp_trip = 0;
        advance_to(8);
        phase_dir = 1; lvl_a = 0; lvl_b = 1;
        idle(4);
        chk("R2 dac held mid-period", dac_code, 3'b110);
        chk("R2 switches held mid-period", sw, 4'b1001);
        advance_to(15);
        tick();
        chk("R2 new level at start", dac_code, 3'b001);
        chk("R7 charge with 38", sw, 4'b1001);
        advance_to(15);
        chk("R6 whole period charge", mode_o, 1);
    endtask

    task automatic t_zero();
        phase_dir = 0; lvl_a = 0; lvl_b = 0;
        tick();
        chk("R1 zero ignores direction", dac_code, 0);
        chk("R9 zero mode off", mode_o, 0);
        cmp_trip = 1;
        idle(50);
        chk("R9 zero with trip", sw, 0);
        advance_to(6);
        chk("R9 zero at mixed point", sw, 0);
        cmp_trip = 0;
        advance_to(15);
    endtask

    task automatic t_collide();
        phase_dir = 1; lvl_a = 1; lvl_b = 1;
        tick();
        idle(50);
        advance_to(5);
        chk("R6 charge before collision", mode_o, 1);
        cmp_trip = 1;
        idle(2);
        tick();
        chk("R11 trip with mixed strobe fast", mode_o, 3);
        advance_to(15);
        tick();
        chk("R11 wrap gives charge", mode_o, 1);
        idle(20);
        chk("R4 blank restarted", mode_o, 1);
        idle(30);
        chk("R4 trip after blank", mode_o, 2);
        cmp_trip = 0;
    endtask

    task automatic t_standby();
        standby_n = 0;
        idle(2);
        chk("R10 standby switches", sw, 0);
        chk("R10 standby dac", dac_code, 0);
        tick(); idle(2); tick();
        chk("R10 strobes ignored", mode_o, 0);
        standby_n = 1;
        pos_b = 15;
        idle(5);
        chk("R10 idle after release", mode_o, 0);
        tick();
        chk("R10 first strobe starts", mode_o, 1);
        chk("R10 first strobe level", dac_code, 3'b011);
    endtask

    initial begin
        idle(4);
        rst = 0;
        idle(1);
        t_reset();
        t_early_trip_pos();
        t_late_trip();
        t_negative_and_hold();
        t_zero();
        t_collide();
        t_standby();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule